// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps wall-clock time and date as seven packed BCD counters: seconds, minutes, hours (24-hour form), a day-of-week count, day of month, month and two-digit year. A one-cycle pulse from an external one-second prescaler advances the seconds counter. Each counter passes its rollover on to the next. Month lengths and the leap-year February are applied automatically.

A serial front end loads the counters with one 52-bit word. It reads them back through the same 52-bit frame, which is always present on the output. While a write is in progress the front end raises a hold input, and ticks that arrive during the hold are dropped. A one-cycle minute carry pulse marks each rollover of the seconds counter.

The load word is a plain strobe with no back-pressure. The counter always accepts it in the cycle in which it is raised, so no ready signal exists.

Top module: `rtc_calendar`

## Requirements
- R1: On each accepted tick, seconds count 00..59 in BCD. Minutes advance when seconds wrap from 59 to 00, and minutes also count 00..59.
- R2: Hours count 00..23 and wrap to 00. When they wrap, the day of month and the weekday both advance.
- R3: The weekday (frame bits 26:24) counts 1..7 and wraps from 7 back to 1. It advances only when the hours wrap.
- R4: The day of month wraps to 01 after 31 in January, March, May, July, August, October and December, and after 30 in April, June, September and November. When it wraps, the month advances.
- R5: A year is a leap year when its value is divisible by 4, with 00 counted as a leap year. In a leap year February runs to 29; otherwise day 28 of February is followed by March 1.
- R6: The month wraps from 12 to 01 and the year then advances. The year wraps from 99 to 00.
- R7: A tick that arrives while hold_i is high is dropped and changes no output. Counting resumes with the first tick after hold_i falls.
- R8: When load_i is high, all seven counters take their values from load_word_i at the next clock edge. This holds even when a tick arrives in the same cycle, and the load wins over the tick.
- R9: The frame is laid out LSB first, with field positions that the serial front end relies on:
  - seconds at bits 6:0, with bit 7 as the voltage flag;
  - minutes at bits 14:8;
  - hours at bits 21:16;
  - weekday at bits 26:24;
  - day at bits 33:28;
  - month at bits 40:36, with bit 43 as the test bit;
  - year at bits 51:44.
  
  Bits 7, 15, 23:22, 27, 35:34 and 43:41, which include the voltage flag and the test bit, always read 0 and are ignored on load.
- R10: After reset the frame reads 00:00:00, weekday 1, day 01, month 01, year 00, and the minute carry is low.
- R11: min_carry_o goes high for exactly one cycle, in the same cycle that the seconds field first shows 00 after wrapping from 59.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick_i | input | 1 | One-cycle pulse, once per second |
| hold_i | input | 1 | Drops ticks while a write is in progress |
| load_i | input | 1 | Load strobe for load_word_i |
| load_word_i | input | 52 | Packed BCD frame to load |
| cal_word_o | output | 52 | Current packed BCD frame |
| min_carry_o | output | 1 | One-cycle pulse on a seconds wrap |

## Verification
The conditions that are hard to reach from the ports are the rare rollovers: a leap-day February, New Year's Eve of year 99, and the 30-day month ends. Reaching any of them by ticking alone would take months or years of simulated seconds. The stimulus therefore loads a frame one second before each boundary and then applies a single tick. The scoreboard's calendar model, written independently from the requirements, predicts the full 52-bit frame and the carry for that tick. Load and tick in the same cycle, ticks under hold, and loads with every reserved bit set are also driven directly.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int FRAME_W    = 52;
  localparam int DIG_W      = 8;
  localparam int NUM_FIELDS = 7;

  // field index: 0 sec, 1 min, 2 hour, 3 weekday, 4 day, 5 month, 6 year
  localparam int FIELD_LSB [NUM_FIELDS] = '{0, 8, 16, 24, 28, 36, 44};
  localparam logic [DIG_W-1:0] FIELD_MASK [NUM_FIELDS] =
    '{8'h7F, 8'h7F, 8'h3F, 8'h07, 8'h3F, 8'h1F, 8'hFF};
  localparam logic [DIG_W-1:0] FIELD_RST [NUM_FIELDS] =
    '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00};
  localparam logic [DIG_W-1:0] FIELD_LO [NUM_FIELDS] =
    '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00};
  localparam logic [DIG_W-1:0] FIELD_HI [NUM_FIELDS] =
    '{8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99};

  localparam logic [FRAME_W-1:0] FRAME_LIVE =
    {8'hFF, 8'h1F, 8'h3F, 4'h7, 8'h3F, 8'h7F, 8'h7F};

  function automatic logic [DIG_W-1:0] bcd_next(input logic [DIG_W-1:0] v);
    if (v[3:0] >= 4'd9) bcd_next = {v[7:4] + 4'd1, 4'd0};
    else                bcd_next = {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic year_is_leap(input logic [DIG_W-1:0] y);
    if (y[4]) year_is_leap = (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    else      year_is_leap = (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction
endpackage

// File: rtl/rtc_month_limit.sv
module rtc_month_limit
  import rtc_cal_pkg::*;
(
  input  logic [DIG_W-1:0] month_i,
  input  logic [DIG_W-1:0] year_i,
  output logic [DIG_W-1:0] last_day_o
);
  always_comb begin
    unique case (month_i)
      8'h02:                      last_day_o = year_is_leap(year_i) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day_o = 8'h30;
      default:                    last_day_o = 8'h31;
    endcase
  end
endmodule

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field
  import rtc_cal_pkg::*;
#(
  parameter logic [DIG_W-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [DIG_W-1:0] load_val_i,
  input  logic             step_i,
  input  logic [DIG_W-1:0] lo_i,
  input  logic [DIG_W-1:0] hi_i,
  output logic [DIG_W-1:0] value_o
);
  logic [DIG_W-1:0] q;

  always_ff @(posedge clk) begin
    if (!rst_n)      q <= RESET_VAL;
    else if (load_i) q <= load_val_i;
    else if (step_i) q <= (q >= hi_i) ? lo_i : bcd_next(q);
  end

  assign value_o = q;
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sec_tick_i,
  input  logic               hold_i,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] load_word_i,
  output logic [FRAME_W-1:0] cal_word_o,
  output logic               min_carry_o
);
  logic [DIG_W-1:0] val  [NUM_FIELDS];
  logic [DIG_W-1:0] hi   [NUM_FIELDS];
  logic             step [NUM_FIELDS];
  logic             top  [NUM_FIELDS-1];
  logic [DIG_W-1:0] month_end;

  rtc_month_limit u_limit (
    .month_i    (val[5]),
    .year_i     (val[6]),
    .last_day_o (month_end)
  );

  always_comb begin
    for (int i = 0; i < NUM_FIELDS; i++) hi[i] = FIELD_HI[i];
    hi[4] = month_end;
    for (int i = 0; i < NUM_FIELDS-1; i++) top[i] = (val[i] >= hi[i]);
  end

  // rollover chain; weekday (3) steps together with day (4)
  always_comb begin
    step[0] = sec_tick_i & ~hold_i & ~load_i;
    step[1] = step[0] & top[0];
    step[2] = step[1] & top[1];
    step[3] = step[2] & top[2];
    step[4] = step[3];
    step[5] = step[4] & top[4];
    step[6] = step[5] & top[5];
  end

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    rtc_bcd_field #(.RESET_VAL(FIELD_RST[g])) u_field (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (load_i),
      .load_val_i (load_word_i[FIELD_LSB[g] +: DIG_W] & FIELD_MASK[g]),
      .step_i     (step[g]),
      .lo_i       (FIELD_LO[g]),
      .hi_i       (hi[g]),
      .value_o    (val[g])
    );
  end

  always_comb begin
    cal_word_o = '0;
    for (int i = 0; i < NUM_FIELDS; i++)
      cal_word_o = cal_word_o | (FRAME_W'(val[i]) << FIELD_LSB[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) min_carry_o <= 1'b0;
    else        min_carry_o <= step[1];
  end
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk
  import rtc_cal_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               sec_tick_i,
  input logic               hold_i,
  input logic               load_i,
  input logic [FRAME_W-1:0] load_word_i,
  input logic [FRAME_W-1:0] cal_word_o,
  input logic               min_carry_o
);
  a_r7_hold_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_i && !load_i) |=> $stable(cal_word_o));

  a_r1_no_tick_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_tick_i && !load_i) |=> $stable(cal_word_o));

  a_r8_load_applies: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cal_word_o == ($past(load_word_i) & FRAME_LIVE)));

  a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_word_o & ~FRAME_LIVE) == '0);

  a_r3_weekday_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> (cal_word_o[26:24] != 3'd0));

  a_r11_carry_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    min_carry_o |-> (cal_word_o[6:0] == 7'd0));

  a_r11_carry_single: assert property (@(posedge clk) disable iff (!rst_n)
    min_carry_o |=> !min_carry_o);
endmodule

bind rtc_calendar rtc_calendar_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sec_tick_i  (sec_tick_i),
  .hold_i      (hold_i),
  .load_i      (load_i),
  .load_word_i (load_word_i),
  .cal_word_o  (cal_word_o),
  .min_carry_o (min_carry_o)
);

// File: tb/rtc_calendar_test.sv
module rtc_calendar_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sec_tick_i = 1'b0;
  logic        hold_i = 1'b0;
  logic        load_i = 1'b0;
  logic [51:0] load_word_i = '0;
  logic [51:0] cal_word_o;
  logic        min_carry_o;

  rtc_calendar uut (
    .clk(clk), .rst_n(rst_n), .sec_tick_i(sec_tick_i), .hold_i(hold_i),
    .load_i(load_i), .load_word_i(load_word_i),
    .cal_word_o(cal_word_o), .min_carry_o(min_carry_o)
  );

  always #5 clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  logic [51:0] q_word [$];
  logic        q_carry [$];
  string       q_tag [$];

  // reference model state, plain integers
  int m_s, m_mi, m_h, m_w, m_d, m_mo, m_y;
  bit m_c;

  function automatic logic [7:0] to_bcd(int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic logic [51:0] pack(int s, int mi, int h, int w, int d, int mo, int y);
    return {to_bcd(y), to_bcd(mo), to_bcd(d), 4'(w), to_bcd(h), to_bcd(mi), to_bcd(s)};
  endfunction

  function automatic int month_len(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [51:0] reserved_bits();
    logic [51:0] r = '0;
    r[7] = 1'b1; r[15] = 1'b1; r[23:22] = 2'b11; r[27] = 1'b1;
    r[35:34] = 2'b11; r[43:41] = 3'b111;
    return r;
  endfunction

  task automatic model_tick();
    m_c = 0;
    m_s++;
    if (m_s < 60) return;
    m_s = 0; m_c = 1; m_mi++;
    if (m_mi < 60) return;
    m_mi = 0; m_h++;
    if (m_h < 24) return;
    m_h = 0;
    m_w = (m_w == 7) ? 1 : m_w + 1;
    m_d++;
    if (m_d <= month_len(m_mo, m_y)) return;
    m_d = 1; m_mo++;
    if (m_mo <= 12) return;
    m_mo = 1;
    m_y = (m_y + 1) % 100;
  endtask

  task automatic push_exp(string tag);
    q_word.push_back(pack(m_s, m_mi, m_h, m_w, m_d, m_mo, m_y));
    q_carry.push_back(m_c);
    q_tag.push_back(tag);
  endtask

  task automatic do_tick(bit hd, string tag);
    @(negedge clk);
    sec_tick_i = 1'b1; hold_i = hd; load_i = 1'b0;
    if (hd) m_c = 0; else model_tick();
    push_exp(tag);
  endtask

  task automatic do_idle(string tag);
    @(negedge clk);
    sec_tick_i = 1'b0; hold_i = 1'b0; load_i = 1'b0;
    m_c = 0;
    push_exp(tag);
  endtask

  task automatic do_load(int s, int mi, int h, int w, int d, int mo, int y,
                         bit junk, bit tk, string tag);
    @(negedge clk);
    load_word_i = pack(s, mi, h, w, d, mo, y) | (junk ? reserved_bits() : 52'd0);
    load_i = 1'b1; sec_tick_i = tk; hold_i = 1'b0;
    m_s = s; m_mi = mi; m_h = h; m_w = w; m_d = d; m_mo = mo; m_y = y; m_c = 0;
    push_exp(tag);
  endtask

  // boundary helper: load one second before, then a single tick
  task automatic edge_case(int h, int w, int d, int mo, int y, string tag);
    do_load(59, 59, h, w, d, mo, y, 0, 0, {tag, " load"});
    do_tick(0, tag);
  endtask

  // monitor: one comparison per driven cycle, sampled after the edge
  always @(posedge clk) begin
    #2;
    if (q_word.size() > 0) begin
      logic [51:0] ew;
      logic        ec;
      string       et;
      ew = q_word.pop_front();
      ec = q_carry.pop_front();
      et = q_tag.pop_front();
      n_vec++;
      if (cal_word_o !== ew || min_carry_o !== ec) begin
        n_bad++;
        $display("FAIL %s: word=%h carry=%b expected word=%h carry=%b",
                 et, cal_word_o, min_carry_o, ew, ec);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    m_s = 0; m_mi = 0; m_h = 0; m_w = 1; m_d = 1; m_mo = 1; m_y = 0; m_c = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    n_vec++;
    if (cal_word_o !== pack(0, 0, 0, 1, 1, 1, 0) || min_carry_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R10 reset: word=%h carry=%b expected word=%h carry=0",
               cal_word_o, min_carry_o, pack(0, 0, 0, 1, 1, 1, 0));
    end

    repeat (3) do_tick(0, "R1 seconds count");
    do_idle("R1 idle no change");
    do_load(57, 0, 0, 3, 15, 6, 21, 0, 0, "R8 load");
    repeat (4) do_tick(0, "R1 R11 minute carry");
    edge_case(0, 3, 15, 6, 21, "R1 minute to hour");
    edge_case(23, 7, 10, 3, 21, "R2 R3 day and weekday wrap");
    edge_case(23, 2, 31, 1, 21, "R4 january end");
    edge_case(23, 4, 30, 4, 21, "R4 april end");
    edge_case(23, 5, 30, 1, 21, "R4 january 30");
    edge_case(23, 1, 28, 2, 24, "R5 leap feb 28");
    edge_case(23, 1, 29, 2, 24, "R5 leap feb 29");
    edge_case(23, 1, 28, 2, 23, "R5 common feb 28");
    edge_case(23, 1, 28, 2, 0, "R5 year 00 leap");
    edge_case(23, 1, 28, 2, 10, "R5 year 10 common");
    edge_case(23, 1, 28, 2, 12, "R5 year 12 leap");
    edge_case(23, 6, 31, 12, 99, "R6 year 99 wrap");
    edge_case(23, 6, 31, 12, 41, "R6 december end");
    do_load(30, 20, 10, 4, 5, 7, 33, 0, 0, "R7 load");
    do_tick(1, "R7 tick under hold");
    do_tick(1, "R7 tick under hold");
    do_idle("R7 released idle");
    do_tick(0, "R7 resumes");
    do_load(59, 59, 23, 7, 31, 12, 99, 0, 1, "R8 load beats tick");
    do_idle("R8 after load");
    do_load(45, 37, 19, 2, 23, 11, 58, 1, 0, "R9 reserved bits masked");
    do_tick(0, "R9 tick after masked load");
    do_idle("final idle");
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule